// File: doc/BRIEF.md
# Switching-Event Bus Packetizer

This block sits between a multi-channel PWM generator and a set of remote power modules that share one data bus. It watches the 2-bit switching state of each module channel. Whenever a channel's state changes, the block turns that change into a short addressed packet on the shared bus, so separate gate wires to each module are not needed.

Each channel has its own change detector and a sticky request flag. A fixed-priority picker chooses one pending channel. A slot controller then drives the packet over a fixed three-cycle slot, and clears that channel's request when it captures the state. The first cycle sets up the address and state. The second cycle raises the trigger strobe, which the modules use as their latch point. The third cycle releases the bus.

The bus output acts as a valid-only stream. `pkt_valid` marks the cycles in which address and state are meaningful. There is no ready input: the remote modules cannot stall, so there is no back-pressure. While a slot is running, further changes wait in their request flags.

Top module: `sw_event_packetizer`

## Requirements
- R1: After reset `req_pending`, `pkt_valid` and `pkt_trig` are low and `pkt_addr`/`pkt_state` read 0. They stay so while no channel state changes.
- R2: A change in any bit of a channel's 2-bit state input makes `req_pending` high one cycle after the change is sampled.
- R3: A packet occupies three cycles: (1) `pkt_valid`=1, `pkt_trig`=0, address and state set; (2) `pkt_valid`=1, `pkt_trig`=1, same address and state; (3) `pkt_valid`=0, `pkt_trig`=0. A lone change sampled at edge k puts cycle (1) after edge k+1.
- R4: When several channels are pending, they are served in ascending channel index order.
- R5: A channel that changes again while waiting keeps one request, and its packet carries the most recent state.
- R6: If a channel changes in the same cycle that its request is cleared by selection, the new change wins. The request stays set and a second packet with the newer state follows.
- R7: `pkt_addr` is the binary channel index, 0 to 8. Values 9 to 15 never appear while `pkt_valid` is high. `pkt_state` equals the channel's 2-bit state input as sampled.
- R8: Pending packets are sent back to back. The next packet's setup cycle directly follows the previous packet's release cycle, giving one packet every three cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_state | input | 18 | Channel i state in bits [2i+1:2i] |
| pkt_valid | output | 1 | Bus driven: address and state meaningful |
| pkt_addr | output | 4 | Channel index of the packet |
| pkt_state | output | 2 | Switching state carried by the packet |
| pkt_trig | output | 1 | Latch strobe, middle cycle of the slot |
| req_pending | output | 1 | At least one channel waits for service |

## Verification
The assertions assume that `chan_state` reads 0 when reset is released. The change detectors start from that value, so a non-zero state at reset release would show up as a change. They also assume the input changes only at clock edges. The stimulus holds all channels at 0 through reset and changes channel states only on the falling edge. It sets up same-channel changes both while a channel is waiting and exactly in its selection cycle, so the sticky-request and clear-collision rules are exercised.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_SETUP = 2'd1,
    SL_TRIG  = 2'd2,
    SL_REL   = 2'd3
  } slot_e;
endpackage

// File: rtl/sw_edge_req.sv
module sw_edge_req #(
  parameter int ST_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] st_in,
  input  logic            clr,
  output logic            req,
  output logic [ST_W-1:0] st_hold
);
  logic [ST_W-1:0] prev_q;
  logic            chg;

  assign chg     = (st_in != prev_q);
  assign st_hold = prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req    <= 1'b0;
    end else begin
      prev_q <= st_in;
      // a fresh change beats a clear in the same cycle
      req    <= chg | (req & ~clr);
    end
  end

  // R2 and R6: a change always leaves the request set
  a_r6_change_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> req);

  // R5: a waiting request is only dropped by a clear
  a_r5_hold_until_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !clr) |=> req);
endmodule

// File: rtl/pkt_arbiter.sv
module pkt_arbiter #(
  parameter int N  = 9,
  parameter int AW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [AW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = AW'(i);
      end
    end
  end

  assign grant = any ? (N'(1) << idx) : '0;
endmodule

// File: rtl/pkt_bus_ctrl.sv
module pkt_bus_ctrl
  import pkt_pkg::*;
#(
  parameter int N  = 9,
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any,
  input  logic [AW-1:0] idx,
  input  logic [N-1:0]  grant,
  input  logic [SW-1:0] st_sel,
  output logic [N-1:0]  clr,
  output logic          bus_en,
  output logic [AW-1:0] bus_addr,
  output logic [SW-1:0] bus_state,
  output logic          bus_trig
);
  slot_e         sl_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] st_q;
  logic          take;

  assign take = any && (sl_q == SL_IDLE || sl_q == SL_REL);
  assign clr  = take ? grant : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sl_q   <= SL_IDLE;
      addr_q <= '0;
      st_q   <= '0;
    end else begin
      unique case (sl_q)
        SL_IDLE, SL_REL: begin
          if (take) begin
            sl_q   <= SL_SETUP;
            addr_q <= idx;
            st_q   <= st_sel;
          end else begin
            sl_q   <= SL_IDLE;
          end
        end
        SL_SETUP: sl_q <= SL_TRIG;
        SL_TRIG:  sl_q <= SL_REL;
        default:  sl_q <= SL_IDLE;
      endcase
    end
  end

  assign bus_en    = (sl_q == SL_SETUP) || (sl_q == SL_TRIG);
  assign bus_trig  = (sl_q == SL_TRIG);
  assign bus_addr  = bus_en ? addr_q : '0;
  assign bus_state = bus_en ? st_q : '0;

  // R3: strobe comes after a setup cycle with the bus already driven
  a_r3_setup_before_trig: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trig |-> $past(bus_en && !bus_trig));
  // R3: address and state do not move under the strobe
  a_r3_stable_under_trig: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trig |-> ($stable(bus_addr) && $stable(bus_state)));
  // R3: bus released right after the strobe
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trig |=> (!bus_en && !bus_trig));
  // R7: only real channel addresses are driven
  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (bus_addr < AW'(N)));
  // R6: at most one request is cleared per cycle
  a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
endmodule

// File: rtl/sw_event_packetizer.sv
module sw_event_packetizer #(
  parameter int NUM_CH = 9,
  parameter int ST_W   = 2,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH*ST_W-1:0] chan_state,
  output logic                   pkt_valid,
  output logic [ADDR_W-1:0]      pkt_addr,
  output logic [ST_W-1:0]        pkt_state,
  output logic                   pkt_trig,
  output logic                   req_pending
);
  localparam int MIN_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] req;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] grant;
  logic [ST_W-1:0]   hold [NUM_CH];
  logic              any;
  logic [ADDR_W-1:0] idx;
  logic [ST_W-1:0]   st_sel;

  initial begin
    if (ADDR_W < MIN_AW) $error("ADDR_W too narrow for NUM_CH");
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sw_edge_req #(.ST_W(ST_W)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .st_in  (chan_state[g*ST_W +: ST_W]),
      .clr    (clr[g]),
      .req    (req[g]),
      .st_hold(hold[g])
    );
  end

  pkt_arbiter #(.N(NUM_CH), .AW(ADDR_W)) u_arb (
    .req  (req),
    .any  (any),
    .idx  (idx),
    .grant(grant)
  );

  always_comb begin
    st_sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx == ADDR_W'(i)) st_sel = hold[i];
    end
  end

  pkt_bus_ctrl #(.N(NUM_CH), .AW(ADDR_W), .SW(ST_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .any      (any),
    .idx      (idx),
    .grant    (grant),
    .st_sel   (st_sel),
    .clr      (clr),
    .bus_en   (pkt_valid),
    .bus_addr (pkt_addr),
    .bus_state(pkt_state),
    .bus_trig (pkt_trig)
  );

  assign req_pending = |req;

  // R4: a cleared channel never has a lower-index channel still waiting
  a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> ((req & (clr - NUM_CH'(1))) == '0));
endmodule

// File: tb/sw_event_packetizer_tb.sv
module sw_event_packetizer_tb;
  localparam int NCH = 9;
  localparam int NV  = 12;
  localparam logic [3:0] V_CH [NV] = '{4'd0, 4'd8, 4'd4, 4'd0, 4'd8, 4'd3,
                                       4'd5, 4'd4, 4'd1, 4'd7, 4'd2, 4'd6};
  localparam logic [1:0] V_ST [NV] = '{2'd1, 2'd3, 2'd2, 2'd2, 2'd0, 2'd1,
                                       2'd3, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH*2-1:0] st_drv = '0;
  logic             pkt_valid, pkt_trig, req_pending;
  logic [3:0]       pkt_addr;
  logic [1:0]       pkt_state;
  int               n_chk = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  always #2.5 clk = ~clk;

  sw_event_packetizer u_dut (
    .clk(clk), .rst_n(rst_n), .chan_state(st_drv),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_state(pkt_state),
    .pkt_trig(pkt_trig), .req_pending(req_pending)
  );

  function automatic logic [31:0] pk(logic en, logic tr, logic [3:0] a, logic [1:0] s);
    return {24'd0, en, tr, a, s};
  endfunction

  function automatic logic [31:0] bus_now();
    return pk(pkt_valid, pkt_trig, pkt_addr, pkt_state);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic set_ch(input int c, input logic [1:0] v);
    st_drv[c*2 +: 2] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1 reset bus", bus_now(), pk(0, 0, 0, 0));
    chk("R1 reset pending", 32'(req_pending), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 quiet bus", bus_now(), pk(0, 0, 0, 0));
    end
    chk("R1 quiet pending", 32'(req_pending), 32'd0);

    // Table walk: single changes, R2 R3 R7
    for (int e = 0; e < NV; e++) begin
      @(negedge clk);
      set_ch(int'(V_CH[e]), V_ST[e]);
      @(negedge clk);
      chk("R2 pending after change", 32'(req_pending), 32'd1);
      @(negedge clk);
      chk("R3 R7 setup cycle", bus_now(), pk(1, 0, V_CH[e], V_ST[e]));
      @(negedge clk);
      chk("R3 R7 trigger cycle", bus_now(), pk(1, 1, V_CH[e], V_ST[e]));
      @(negedge clk);
      chk("R3 release cycle", bus_now(), pk(0, 0, 0, 0));
      chk("R3 pending cleared", 32'(req_pending), 32'd0);
    end

    // R4 and R8: three channels change together
    @(negedge clk);
    set_ch(7, 2'd1);
    set_ch(2, 2'd2);
    set_ch(5, 2'd1);
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      case (n)
        3:  chk("R4 first packet lowest", bus_now(), pk(1, 1, 4'd2, 2'd2));
        5:  chk("R8 back-to-back setup", bus_now(), pk(1, 0, 4'd5, 2'd1));
        6:  chk("R4 second packet", bus_now(), pk(1, 1, 4'd5, 2'd1));
        9:  chk("R4 third packet", bus_now(), pk(1, 1, 4'd7, 2'd1));
        10: chk("R8 all served", 32'(req_pending), 32'd0);
        default: ;
      endcase
    end

    // R5: waiting channel changes again
    @(negedge clk);
    set_ch(1, 2'd3);
    set_ch(3, 2'd2);
    for (int n = 1; n <= 13; n++) begin
      @(negedge clk);
      if (n == 1) set_ch(3, 2'd0);
      if (n == 3) chk("R5 blocker packet", bus_now(), pk(1, 1, 4'd1, 2'd3));
      if (n == 6) chk("R5 latest state sent", bus_now(), pk(1, 1, 4'd3, 2'd0));
      if (n == 7) chk("R5 single request", 32'(req_pending), 32'd0);
      if (n > 7)  chk("R5 no extra packet", bus_now(), pk(0, 0, 0, 0));
    end

    // R6: change lands in the selection cycle
    @(negedge clk);
    set_ch(4, 2'd3);
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      if (n == 1) set_ch(4, 2'd0);
      if (n == 2) chk("R6 request survives clear", 32'(req_pending), 32'd1);
      if (n == 3) chk("R6 first packet", bus_now(), pk(1, 1, 4'd4, 2'd3));
      if (n == 6) chk("R6 second packet newer", bus_now(), pk(1, 1, 4'd4, 2'd0));
      if (n == 7) chk("R6 served", 32'(req_pending), 32'd0);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule